// File: doc/BRIEF.md
# Strobe Delay Window Calibrator

This block tunes the strobe timing of a DDR memory interface without software help. It walks a two-level grid. The outer level is a write-strobe shift and the inner level is a read-strobe delay-line setting. At every grid point it programs the interface, restarts the memory controller, waits for the delay line to lock and for memory initialisation to finish, and lets the interface settle. It then writes a fixed 64-word pattern and reads each word back several times.

Across the grid it keeps the longest unbroken run of passing delay values. A later run of equal length replaces an earlier one. When the sweep ends it programs the shift of the best run together with the midpoint of that run's delays. It restarts the controller once more and then reports completion. If any handshake never arrives the block stops and raises a failure output. If no point ever passes it falls back to fixed settings and flags that no window was found.

The block is started with a single-cycle pulse. It drives the interface settings directly and talks to memory over a simple request/response port.

Top module: `strobe_eye_cal`

## Requirements
- R1: The shift setting steps from SHIFT_LO to SHIFT_HI (64..95). For each shift, the delay steps from DLY_LO to DLY_HI (1..63). At every rising edge of `ctrlStart` during the sweep, `cfgWrShift` and the delay of all LANES lanes show the point under test, and `cfgOutShift` equals `cfgWrShift` + 32.
- R2: Each sweep point follows a fixed order:
  - `ctrlStart` is low.
  - A one-cycle `errAck` with `errAckMask` = 0x3C occurs while `ctrlStart` is low.
  - `ctrlStart` rises.
  - The block waits for `dllLocked`, then for `initDone`.
  - The first memory request comes exactly SETTLE_CYC+1 cycles after the cycle in which `initDone` is first seen high.
  - Memory requests are issued only while `ctrlStart` is high, and `ctrlStart` falls after the test.
- R3: If `dllLocked` or `initDone` is not seen within POLL_MAX cycles of polling, the block stops with `calFail` high, `calDone` low and `ctrlStart` low. For the lock wait, `calFail` rises exactly POLL_MAX cycles after `ctrlStart` rises.
- R4: Each test writes WORDS words to addresses 0,1,2,… in order. The word at index i has a 16-bit seed replicated across the data width:
  - i[5:4] selects the group (0: 0000/FFFF, 1: AAAA/5555, 2: A5A5/5A5A, 3: AA55/55AA).
  - i[1]^i[3] selects the second value of the group.
- R5: After the writes, each word is read READS times in address order. No request follows the first mismatching response of a point.
- R6: A point fails on any readback mismatch, or if `errStatus` & 0x3F is nonzero when the test ends. Bits 6 and 7 of `errStatus` have no effect.
- R7: A failing point clears the current run, and a new shift also starts a new run. A pass extends the run. If the run length is greater than or equal to the best so far, the block stores the run length, the shift, the run's first delay and the current delay as the new best, so a later tie wins.
- R8: After the last point, the block programs the best shift, that shift + 32, and delay = (best first + best last) / 2 rounded down on all lanes. It then repeats start, lock, init and settle, and raises `calDone` with `ctrlStart` left high.
- R9: If no point passed, the final settings are delay 0 and shift SHIFT_LO, and both `calDone` and `noWindow` are high.
- R10: After reset, `calDone`, `calFail`, `noWindow`, `ctrlStart` and `reqValid` are low, `cfgWrShift` is SHIFT_LO and all lane delays are 0.
- R11: While `reqValid` is high and `reqReady` is low, the request (address, write flag) stays unchanged. Only one read is outstanding at a time, and writes get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| calStart | input | 1 | Start pulse; accepted when idle, done or failed |
| cfgWrShift | output | SHIFT_W | Write-strobe shift setting |
| cfgOutShift | output | SHIFT_W | Output-strobe shift, write shift + 32 |
| cfgLaneDelay | output | LANES*DLY_W | Read-strobe delay per byte lane, all equal |
| ctrlStart | output | 1 | Memory controller start |
| errAck | output | 1 | One-cycle error acknowledge strobe |
| errAckMask | output | ERR_W | Bits cleared by the acknowledge (0x3C) |
| dllLocked | input | 1 | Delay line locked |
| initDone | input | 1 | Memory initialisation complete |
| errStatus | input | ERR_W | Sticky error status bits |
| reqValid | output | 1 | Memory request valid |
| reqReady | input | 1 | Memory request accepted |
| reqWrite | output | 1 | Request is a write |
| reqAddr | output | WORD_W | Word address |
| reqWdata | output | DATA_W | Write data |
| rspValid | input | 1 | Read response valid |
| rspData | input | DATA_W | Read response data |
| calDone | output | 1 | Calibration finished |
| calFail | output | 1 | Handshake timeout |
| noWindow | output | 1 | No passing point was found |

## Verification
The evaluation cycle of a point can do three things at once: extend the current run, capture that run as the best result, and step to a new shift, which must clear the run. The bench provokes all three together. In one shift, a passing run of four ends on the last delay, so it is captured in the same cycle that the shift steps. It ties an earlier run of four, and the next shift then produces a third run of four. The final shift and centred delay can only match the bench's arithmetic if all three actions apply correctly in that one cycle.

// File: rtl/eyecal_pkg.sv
package eyecal_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ACK, S_START, S_LOCK, S_INIT, S_SETTLE,
    S_WRITE, S_RDREQ, S_RDWAIT, S_EVAL, S_APPLY, S_DONE, S_FAIL
  } calState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sweepInit;
    logic waitClr;
    logic waitInc;
    logic testClr;
    logic wrAdv;
    logic rdResp;
    logic evalStep;
    logic applyBest;
  } dpCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic pollExpired;
    logic settleDone;
    logic lastWord;
    logic lastRead;
    logic rspMatch;
    logic lastPoint;
  } dpStat_t;

  // 16-bit seed of the test word at a given index
  function automatic logic [15:0] patSeed(input logic [5:0] idx);
    logic sel;
    sel = idx[1] ^ idx[3];
    case (idx[5:4])
      2'd0:    patSeed = sel ? 16'hFFFF : 16'h0000;
      2'd1:    patSeed = sel ? 16'h5555 : 16'hAAAA;
      2'd2:    patSeed = sel ? 16'h5A5A : 16'hA5A5;
      default: patSeed = sel ? 16'h55AA : 16'hAA55;
    endcase
  endfunction

endpackage

// File: rtl/eyecal_dp.sv
module eyecal_dp
  import eyecal_pkg::*;
#(
  parameter int SHIFT_W    = 7,
  parameter int SHIFT_LO   = 64,
  parameter int SHIFT_HI   = 95,
  parameter int OUT_OFFSET = 32,
  parameter int DLY_W      = 6,
  parameter int DLY_LO     = 1,
  parameter int DLY_HI     = 63,
  parameter int WORDS      = 64,
  parameter int READS      = 10,
  parameter int DATA_W     = 32,
  parameter int ERR_W      = 8,
  parameter logic [ERR_W-1:0] FAIL_MASK = 8'h3F,
  parameter int POLL_MAX   = 65535,
  parameter int SETTLE_CYC = 20000,
  localparam int WORD_W    = $clog2(WORDS),
  localparam int READ_W    = $clog2(READS)
) (
  input  logic               clk,
  input  logic               rst,
  input  dpCmd_t             cmd,
  output dpStat_t            stat,
  input  logic [ERR_W-1:0]   errStatus,
  input  logic [DATA_W-1:0]  rspData,
  output logic [SHIFT_W-1:0] shiftQ,
  output logic [SHIFT_W-1:0] outShift,
  output logic [DLY_W-1:0]   delayQ,
  output logic [WORD_W-1:0]  wordIdx,
  output logic [DATA_W-1:0]  patWord,
  output logic               noWin
);

  localparam int MAXW  = (POLL_MAX > SETTLE_CYC) ? POLL_MAX : SETTLE_CYC;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam int SPAN  = DLY_HI - DLY_LO + 1;
  localparam int RUN_W = $clog2(SPAN + 1);
  localparam int REP   = DATA_W / 16;

  logic [CNT_W-1:0]   waitCnt;
  logic [READ_W-1:0]  readIdx;
  logic               mismatch;
  logic [RUN_W-1:0]   runLen, bestLen, runNext;
  logic [DLY_W-1:0]   runStart, bestStart, bestEnd;
  logic [SHIFT_W-1:0] bestShift;
  logic [DLY_W:0]     centreSum;
  logic               pointPass;
  logic               lastDelay;
  logic [5:0]         patIdx;

  assign patIdx    = 6'(wordIdx);
  assign patWord   = {REP{patSeed(patIdx)}};
  assign pointPass = !mismatch && ((errStatus & FAIL_MASK) == '0);
  assign runNext   = runLen + RUN_W'(1);
  assign centreSum = {1'b0, bestStart} + {1'b0, bestEnd};
  assign lastDelay = (delayQ == DLY_W'(DLY_HI));
  assign outShift  = shiftQ + SHIFT_W'(OUT_OFFSET);

  assign stat.pollExpired = (waitCnt == CNT_W'(POLL_MAX - 1));
  assign stat.settleDone  = (waitCnt == CNT_W'(SETTLE_CYC - 1));
  assign stat.lastWord    = (wordIdx == WORD_W'(WORDS - 1));
  assign stat.lastRead    = (readIdx == READ_W'(READS - 1));
  assign stat.rspMatch    = (rspData == patWord);
  assign stat.lastPoint   = lastDelay && (shiftQ == SHIFT_W'(SHIFT_HI));

  // wait counter shared by handshake polling and settling
  always_ff @(posedge clk) begin
    if (rst)              waitCnt <= '0;
    else if (cmd.waitClr) waitCnt <= '0;
    else if (cmd.waitInc) waitCnt <= waitCnt + CNT_W'(1);
  end

  // pattern test indices and mismatch flag
  always_ff @(posedge clk) begin
    if (rst || cmd.testClr) begin
      wordIdx  <= '0;
      readIdx  <= '0;
      mismatch <= 1'b0;
    end else if (cmd.wrAdv) begin
      wordIdx <= stat.lastWord ? '0 : wordIdx + WORD_W'(1);
    end else if (cmd.rdResp) begin
      if (!stat.rspMatch) begin
        mismatch <= 1'b1;
      end else if (stat.lastRead) begin
        readIdx <= '0;
        if (!stat.lastWord) wordIdx <= wordIdx + WORD_W'(1);
      end else begin
        readIdx <= readIdx + READ_W'(1);
      end
    end
  end

  // sweep position, run tracking and best window
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ    <= SHIFT_W'(SHIFT_LO);
      delayQ    <= '0;
      runLen    <= '0;
      runStart  <= '0;
      bestLen   <= '0;
      bestShift <= SHIFT_W'(SHIFT_LO);
      bestStart <= '0;
      bestEnd   <= '0;
      noWin     <= 1'b0;
    end else if (cmd.sweepInit) begin
      shiftQ    <= SHIFT_W'(SHIFT_LO);
      delayQ    <= DLY_W'(DLY_LO);
      runLen    <= '0;
      bestLen   <= '0;
      bestShift <= SHIFT_W'(SHIFT_LO);
      bestStart <= '0;
      bestEnd   <= '0;
      noWin     <= 1'b0;
    end else if (cmd.evalStep) begin
      if (pointPass) begin
        runLen <= runNext;
        if (runLen == '0) runStart <= delayQ;
        if (runNext >= bestLen) begin
          bestLen   <= runNext;
          bestShift <= shiftQ;
          bestStart <= (runLen == '0) ? delayQ : runStart;
          bestEnd   <= delayQ;
        end
      end else begin
        runLen <= '0;
      end
      if (lastDelay) begin
        delayQ <= DLY_W'(DLY_LO);
        runLen <= '0;
        if (!stat.lastPoint) shiftQ <= shiftQ + SHIFT_W'(1);
      end else begin
        delayQ <= delayQ + DLY_W'(1);
      end
    end else if (cmd.applyBest) begin
      if (bestLen == '0) begin
        shiftQ <= SHIFT_W'(SHIFT_LO);
        delayQ <= '0;
        noWin  <= 1'b1;
      end else begin
        shiftQ <= bestShift;
        delayQ <= centreSum[DLY_W:1];
      end
    end
  end

  // R7
  best_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd.sweepInit |=> bestLen >= $past(bestLen));

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    runLen <= RUN_W'(SPAN));

  // R6
  fail_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.evalStep && mismatch |=> runLen == '0);

  // R7
  best_order_chk: assert property (@(posedge clk) disable iff (rst)
    bestLen != '0 |-> bestStart <= bestEnd);

endmodule

// File: rtl/eyecal_ctrl.sv
module eyecal_ctrl
  import eyecal_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    calStart,
  input  logic    dllLocked,
  input  logic    initDone,
  input  logic    reqReady,
  input  logic    rspValid,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    ctrlStart,
  output logic    errAck,
  output logic    reqValid,
  output logic    reqWrite,
  output logic    calDone,
  output logic    calFail
);

  calState_t state, stateNext;
  logic      finalPhase;
  logic      startNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    startNext = ctrlStart;
    case (state)
      S_IDLE, S_DONE, S_FAIL: begin
        if (calStart) begin
          cmd.sweepInit = 1'b1;
          startNext     = 1'b0;
          stateNext     = S_SETUP;
        end
      end
      S_SETUP: stateNext = S_ACK;
      S_ACK:   stateNext = S_START;
      S_START: begin
        startNext   = 1'b1;
        cmd.waitClr = 1'b1;
        stateNext   = S_LOCK;
      end
      S_LOCK: begin
        if (dllLocked) begin
          cmd.waitClr = 1'b1;
          stateNext   = S_INIT;
        end else if (stat.pollExpired) begin
          startNext = 1'b0;
          stateNext = S_FAIL;
        end else begin
          cmd.waitInc = 1'b1;
        end
      end
      S_INIT: begin
        if (initDone) begin
          cmd.waitClr = 1'b1;
          stateNext   = S_SETTLE;
        end else if (stat.pollExpired) begin
          startNext = 1'b0;
          stateNext = S_FAIL;
        end else begin
          cmd.waitInc = 1'b1;
        end
      end
      S_SETTLE: begin
        if (stat.settleDone) begin
          if (finalPhase) begin
            stateNext = S_DONE;
          end else begin
            cmd.testClr = 1'b1;
            stateNext   = S_WRITE;
          end
        end else begin
          cmd.waitInc = 1'b1;
        end
      end
      S_WRITE: begin
        if (reqReady) begin
          cmd.wrAdv = 1'b1;
          if (stat.lastWord) stateNext = S_RDREQ;
        end
      end
      S_RDREQ: if (reqReady) stateNext = S_RDWAIT;
      S_RDWAIT: begin
        if (rspValid) begin
          cmd.rdResp = 1'b1;
          if (!stat.rspMatch || (stat.lastRead && stat.lastWord))
            stateNext = S_EVAL;
          else
            stateNext = S_RDREQ;
        end
      end
      S_EVAL: begin
        cmd.evalStep = 1'b1;
        startNext    = 1'b0;
        stateNext    = stat.lastPoint ? S_APPLY : S_SETUP;
      end
      S_APPLY: begin
        cmd.applyBest = 1'b1;
        stateNext     = S_START;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      ctrlStart  <= 1'b0;
      finalPhase <= 1'b0;
    end else begin
      state     <= stateNext;
      ctrlStart <= startNext;
      if (cmd.sweepInit)      finalPhase <= 1'b0;
      else if (cmd.applyBest) finalPhase <= 1'b1;
    end
  end

  assign errAck   = (state == S_ACK);
  assign reqValid = (state == S_WRITE) || (state == S_RDREQ);
  assign reqWrite = (state == S_WRITE);
  assign calDone  = (state == S_DONE);
  assign calFail  = (state == S_FAIL);

  // R2
  ack_start_low_chk: assert property (@(posedge clk) disable iff (rst)
    errAck |-> !ctrlStart);

  // R2
  test_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> ctrlStart);

  // R3
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(calDone && calFail));

  // R3
  fail_stops_chk: assert property (@(posedge clk) disable iff (rst)
    calFail |-> !ctrlStart);

endmodule

// File: rtl/strobe_eye_cal.sv
module strobe_eye_cal
  import eyecal_pkg::*;
#(
  parameter int SHIFT_W    = 7,
  parameter int SHIFT_LO   = 64,
  parameter int SHIFT_HI   = 95,
  parameter int OUT_OFFSET = 32,
  parameter int DLY_W      = 6,
  parameter int DLY_LO     = 1,
  parameter int DLY_HI     = 63,
  parameter int LANES      = 9,
  parameter int WORDS      = 64,
  parameter int READS      = 10,
  parameter int DATA_W     = 32,
  parameter int ERR_W      = 8,
  parameter logic [ERR_W-1:0] FAIL_MASK = 8'h3F,
  parameter logic [ERR_W-1:0] ACK_MASK  = 8'h3C,
  parameter int POLL_MAX   = 65535,
  parameter int SETTLE_US  = 100,
  parameter int CLK_MHZ    = 200,
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ,
  localparam int WORD_W     = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   calStart,
  output logic [SHIFT_W-1:0]     cfgWrShift,
  output logic [SHIFT_W-1:0]     cfgOutShift,
  output logic [LANES*DLY_W-1:0] cfgLaneDelay,
  output logic                   ctrlStart,
  output logic                   errAck,
  output logic [ERR_W-1:0]       errAckMask,
  input  logic                   dllLocked,
  input  logic                   initDone,
  input  logic [ERR_W-1:0]       errStatus,
  output logic                   reqValid,
  input  logic                   reqReady,
  output logic                   reqWrite,
  output logic [WORD_W-1:0]      reqAddr,
  output logic [DATA_W-1:0]      reqWdata,
  input  logic                   rspValid,
  input  logic [DATA_W-1:0]      rspData,
  output logic                   calDone,
  output logic                   calFail,
  output logic                   noWindow
);

  dpCmd_t            cmd;
  dpStat_t           stat;
  logic [DLY_W-1:0]  delayQ;
  logic [WORD_W-1:0] wordIdx;
  logic [DATA_W-1:0] patWord;

  eyecal_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .calStart  (calStart),
    .dllLocked (dllLocked),
    .initDone  (initDone),
    .reqReady  (reqReady),
    .rspValid  (rspValid),
    .stat      (stat),
    .cmd       (cmd),
    .ctrlStart (ctrlStart),
    .errAck    (errAck),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .calDone   (calDone),
    .calFail   (calFail)
  );

  eyecal_dp #(
    .SHIFT_W    (SHIFT_W),
    .SHIFT_LO   (SHIFT_LO),
    .SHIFT_HI   (SHIFT_HI),
    .OUT_OFFSET (OUT_OFFSET),
    .DLY_W      (DLY_W),
    .DLY_LO     (DLY_LO),
    .DLY_HI     (DLY_HI),
    .WORDS      (WORDS),
    .READS      (READS),
    .DATA_W     (DATA_W),
    .ERR_W      (ERR_W),
    .FAIL_MASK  (FAIL_MASK),
    .POLL_MAX   (POLL_MAX),
    .SETTLE_CYC (SETTLE_CYC)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .stat      (stat),
    .errStatus (errStatus),
    .rspData   (rspData),
    .shiftQ    (cfgWrShift),
    .outShift  (cfgOutShift),
    .delayQ    (delayQ),
    .wordIdx   (wordIdx),
    .patWord   (patWord),
    .noWin     (noWindow)
  );

  // one shared delay fanned out to every byte lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cfgLaneDelay[l*DLY_W +: DLY_W] = delayQ;
  end

  assign errAckMask = ACK_MASK;
  assign reqAddr    = wordIdx;
  assign reqWdata   = patWord;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqWrite));

  // R9
  no_window_chk: assert property (@(posedge clk) disable iff (rst)
    noWindow && calDone |-> cfgLaneDelay == '0 && cfgWrShift == SHIFT_W'(SHIFT_LO));

  // R8
  done_start_chk: assert property (@(posedge clk) disable iff (rst)
    calDone |-> ctrlStart);

endmodule

// File: tb/test_strobe_eye_cal.sv
module test_strobe_eye_cal;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 7, DW = 6, LN = 9, NW = 64, WW = 6, DATW = 32, EW = 8;
  localparam int SH_LO = 64, SH_HI = 66, DL_LO = 1, DL_HI = 8;
  localparam int NR = 3, POLL = 40, SETTLE = 5;
  localparam int NDL = DL_HI - DL_LO + 1;
  localparam int NPTS = (SH_HI - SH_LO + 1) * NDL;

  logic clk = 1'b0, rst = 1'b1, calStart = 1'b0;
  logic [SW-1:0] cfgWrShift, cfgOutShift;
  logic [LN*DW-1:0] cfgLaneDelay;
  logic ctrlStart, errAck;
  logic [EW-1:0] errAckMask;
  logic dllLocked = 1'b0, initDone = 1'b0;
  logic [EW-1:0] errStatus = '0;
  logic reqValid, reqReady = 1'b1, reqWrite;
  logic [WW-1:0] reqAddr;
  logic [DATW-1:0] reqWdata;
  logic rspValid = 1'b0;
  logic [DATW-1:0] rspData = '0;
  logic calDone, calFail, noWindow;

  strobe_eye_cal #(
    .SHIFT_LO(SH_LO), .SHIFT_HI(SH_HI), .DLY_LO(DL_LO), .DLY_HI(DL_HI),
    .WORDS(NW), .READS(NR), .POLL_MAX(POLL), .SETTLE_US(SETTLE), .CLK_MHZ(1)
  ) i_strobe_eye_cal (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int scen = 0, pointIdx = 0, curS = 0, curD = 0;
  bit allowLock = 1, allowInit = 1, ackSeen = 0, prevStart = 0, prevFail = 0;
  bit pend = 0, testSeen = 0, waitFirstReq = 0, prevReq = 0;
  int lockCnt = 0, pAddr = 0, pNum = 0, rdTotal = 0, wrCount = 0, wrBad = 0;
  int initCyc = 0, startCyc = 0;
  int rdCnt [NW];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DATW-1:0] pat(input int i);
    logic [15:0] s;
    logic sel;
    sel = ((i >> 1) & 1) != ((i >> 3) & 1);
    case ((i >> 4) & 3)
      0: s = sel ? 16'hFFFF : 16'h0000;
      1: s = sel ? 16'h5555 : 16'hAAAA;
      2: s = sel ? 16'h5A5A : 16'hA5A5;
      default: s = sel ? 16'h55AA : 16'hAA55;
    endcase
    return {s, s};
  endfunction

  // 0 pass, 1 early mismatch, 2 late mismatch, 3 err 0x04, 4 err 0x20, 5 pass with err 0x40
  function automatic int kindOf(input int sc, input int s, input int d);
    if (sc == 1) return 3;
    case (s)
      64: case (d) 1: return 3; 6: return 1; 7: return 2; 8: return 4; default: return 0; endcase
      65: case (d) 1: return 2; 2: return 1; 3: return 3; 4: return 4; 6: return 5; default: return 0; endcase
      default: case (d) 3: return 2; 8: return 3; default: return 0; endcase
    endcase
  endfunction

  function automatic bit passes(input int k);
    return (k == 0) || (k == 5);
  endfunction

  // bench models and monitor, all acting between clock edges
  always @(negedge clk) begin
    if (rst) begin
      lockCnt = 0; dllLocked = 0; initDone = 0; rspValid = 0; pend = 0;
    end else begin
      cyc++;
      // handshake model
      if (!ctrlStart) begin
        lockCnt = 0; dllLocked = 0; initDone = 0;
      end else begin
        lockCnt++;
        if (dllLocked && allowInit && !initDone) begin
          initDone = 1; initCyc = cyc;
        end
        if (lockCnt >= 2 && allowLock) dllLocked = 1;
      end
      // error acknowledge
      if (errAck) begin
        check(!ctrlStart, "R2 ack with start low", ctrlStart, 0);
        check(errAckMask == 8'h3C, "R2 ack mask", errAckMask, 8'h3C);
        errStatus = errStatus & ~errAckMask;
        ackSeen = 1; rdTotal = 0; wrCount = 0; wrBad = 0; testSeen = 0;
        for (int a = 0; a < NW; a++) rdCnt[a] = 0;
      end
      // start rise: point configuration
      if (ctrlStart && !prevStart) begin
        startCyc = cyc;
        if (pointIdx < NPTS) begin
          curS = SH_LO + pointIdx / NDL;
          curD = DL_LO + pointIdx % NDL;
          check(cfgWrShift == SW'(curS), "R1 shift order", cfgWrShift, curS);
          check(cfgOutShift == SW'(curS + 32), "R1 out shift", cfgOutShift, curS + 32);
          for (int l = 0; l < LN; l++)
            check(cfgLaneDelay[l*DW +: DW] == DW'(curD), "R1 lane delay", cfgLaneDelay[l*DW +: DW], curD);
          check(ackSeen, "R2 ack before start", ackSeen, 1);
          if (pointIdx == 0) waitFirstReq = 1;
        end
        ackSeen = 0;
        pointIdx++;
      end
      // start fall after a test: write and read accounting
      if (!ctrlStart && prevStart && testSeen) begin
        int k, expRd;
        k = kindOf(scen, curS, curD);
        expRd = (k == 1) ? 2 * NR + 2 : NW * NR;
        check(wrCount == NW && wrBad == 0, "R4 write pattern", wrBad, 0);
        check(rdTotal == expRd, "R5 read count", rdTotal, expRd);
      end
      // settle length before the first request
      if (reqValid && !prevReq && waitFirstReq) begin
        check(cyc - initCyc == SETTLE + 1, "R2 settle", cyc - initCyc, SETTLE + 1);
        waitFirstReq = 0;
      end
      // memory model
      rspValid = 0;
      if (pend) begin
        int k;
        k = kindOf(scen, curS, curD);
        rspData = pat(pAddr);
        if ((k == 1 && pAddr == 2 && pNum == 1) || (k == 2 && pAddr == NW - 1 && pNum == NR - 1))
          rspData = rspData ^ 32'h1;
        rspValid = 1; pend = 0;
      end
      reqReady = (cyc % 4) != 3;
      if (reqValid && reqReady) begin
        testSeen = 1;
        if (reqWrite) begin
          int k;
          if (reqAddr != WW'(wrCount) || reqWdata != pat(int'(reqAddr))) wrBad++;
          wrCount++;
          if (int'(reqAddr) == NW - 1) begin
            k = kindOf(scen, curS, curD);
            if (k == 3) errStatus = errStatus | 8'h04;
            if (k == 4) errStatus = errStatus | 8'h20;
            if (k == 5) errStatus = errStatus | 8'h40;
          end
        end else begin
          pend = 1; pAddr = int'(reqAddr); pNum = rdCnt[pAddr];
          rdCnt[pAddr]++; rdTotal++;
        end
      end
      if (calFail && !prevFail && scen == 2)
        check(cyc - startCyc == POLL, "R3 lock timeout length", cyc - startCyc, POLL);
    end
    prevStart = ctrlStart; prevFail = calFail; prevReq = reqValid;
  end

  task automatic doReset();
    rst = 1;
    repeat (3) @(negedge clk);
    errStatus = '0; pointIdx = 0; ackSeen = 0; testSeen = 0; waitFirstReq = 0;
    rst = 0;
    @(negedge clk);
  endtask

  task automatic runCal();
    int n;
    calStart = 1;
    @(negedge clk);
    calStart = 0;
    n = 0;
    while (!calDone && !calFail && n < 60000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expectFinal(input string req, input bit nw, input int s, input int d);
    check(calDone && !calFail, {req, " done"}, calDone, 1);
    check(noWindow == nw, {req, " noWindow"}, noWindow, nw);
    check(cfgWrShift == SW'(s), {req, " final shift"}, cfgWrShift, s);
    check(cfgOutShift == SW'(s + 32), {req, " final out shift"}, cfgOutShift, s + 32);
    for (int l = 0; l < LN; l++)
      check(cfgLaneDelay[l*DW +: DW] == DW'(d), {req, " final delay"}, cfgLaneDelay[l*DW +: DW], d);
    check(ctrlStart, {req, " start held"}, ctrlStart, 1);
    check(pointIdx == NPTS + 1, {req, " start count"}, pointIdx, NPTS + 1);
  endtask

  initial begin
    int bl, bs, bst, ben, run, rst0, centre;
    bit any;
    doReset();
    // R10 reset state
    check(!calDone && !calFail && !noWindow, "R10 status low", {calDone, calFail, noWindow}, 0);
    check(!ctrlStart && !reqValid, "R10 start/req low", {ctrlStart, reqValid}, 0);
    check(cfgWrShift == SW'(SH_LO), "R10 shift", cfgWrShift, SH_LO);
    check(cfgLaneDelay == '0, "R10 delay", 0, 0);

    // scenario 0: window search with ties; expected best computed per R6/R7
    scen = 0;
    bl = 0; bs = SH_LO; bst = 0; ben = 0; any = 0; rst0 = 0;
    for (int s = SH_LO; s <= SH_HI; s++) begin
      run = 0;
      for (int d = DL_LO; d <= DL_HI; d++) begin
        if (passes(kindOf(0, s, d))) begin
          if (run == 0) rst0 = d;
          run++;
          if (run >= bl) begin bl = run; bs = s; bst = rst0; ben = d; any = 1; end
        end else run = 0;
      end
    end
    centre = (bst + ben) / 2;
    runCal();
    expectFinal("R8", 0, bs, centre);
    // R7 later tie wins: third run of four at shift 66 starting at delay 4
    check(cfgWrShift == SW'(66) && centre == 5, "R7 tie later wins", cfgWrShift, 66);
    // R6 bit 6 stays set from shift 65 onward yet shift 66 still counts as passing
    check(errStatus[6] == 1'b1 && cfgWrShift == SW'(66), "R6 upper error bits ignored", cfgWrShift, 66);

    // scenario 1: nothing passes
    doReset();
    scen = 1;
    runCal();
    expectFinal("R9", 1, SH_LO, 0);

    // scenario 2: lock never arrives
    doReset();
    scen = 2; allowLock = 0;
    runCal();
    @(negedge clk);
    check(calFail && !calDone && !ctrlStart, "R3 lock timeout fail", calFail, 1);

    // scenario 3: init never arrives
    doReset();
    scen = 3; allowLock = 1; allowInit = 0;
    runCal();
    @(negedge clk);
    check(calFail && !calDone && !ctrlStart, "R3 init timeout fail", calFail, 1);
    check(pointIdx == 1, "R3 stops at first point", pointIdx, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule